// File: doc/BRIEF.md
# Profile Detrend and Quadrature Accumulator

This block receives intensity profiles as a stream of unsigned integer pixels, one per clock, grouped into profiles of a fixed length. For every profile it fits a least-squares straight line over pixel index, removes that line from each pixel, and tracks the largest and smallest corrected values. It then multiplies each corrected pixel by a per-index sine weight and a per-index cosine weight and sums both products over the profile. The two sums and half the spread of the corrected values are presented together with a one-cycle completion strobe. A later phase-search stage consumes these results.

All arithmetic is integer fixed-point. The line fit uses reciprocal constants derived from the profile length at elaboration, so no divider is built. Pixels are held in two alternating profile buffers, because the subtraction pass needs the fitted line, and the fit needs the complete profile. This lets a new profile arrive while the previous one is still being corrected. The weight tables are loaded through a write port before profiles are streamed.

Top module: `pdq_detrend_quad`

## Requirements
- R1: After reset, `done` is 0 and `sin_sum`, `cos_sum` and `amp` are 0. All weight-table entries read as 0 until they are written.
- R2: Let M = PIX_COUNT, F = FRAC_W and S = SHIFT_W. Let Sy = Σy[i] and Sxy = Σ i·y[i] for i = 0..M-1. Let Sx = M(M-1)/2 and D = M²(M²-1)/12. Let RS = ceil(2^(S+F)/D) and RM = ceil(2^(S+F)/M). The fit then computes slope = ((M·Sxy − Sx·Sy)·RS) >>> S and mean = (Sy·RM) >>> S. It also computes offset = mean − ((slope·(M−1)) >>> 1). Here >>> is an arithmetic shift that floors.
- R3: The corrected pixel is e[i] = ((y[i]·2^F) − offset − slope·i) >>> F. It is a signed value of SAMPLE_W+2 bits, and it never exceeds that range for pixels in 0..2^SAMPLE_W−1.
- R4: `amp` = (max e − min e) >>> 1, with the maximum and minimum taken over all M corrected pixels of the profile.
- R5: `sin_sum` = Σ e[i]·sine_table[i], a signed value of SUM_W bits.
- R6: `cos_sum` = Σ e[i]·cosine_table[i], a signed value of SUM_W bits.
- R7: A pixel is taken at each rising edge where `in_valid` is 1. Idle cycles may appear anywhere. Every M accepted pixels form one profile, and pixel i is the (i+1)-th pixel of that profile.
- R8: `done` is 1 in the cycle that begins M+4 rising edges after the edge that accepts a profile's last pixel. Profiles sent back to back with no idle cycle each produce their own correct result.
- R9: `done` lasts one cycle. `sin_sum`, `cos_sum` and `amp` change only when `done` rises, and they hold their values until the next result.
- R10: A write with `tbl_we`=1 stores `tbl_data` at entry `tbl_addr`. The table is the sine table when `tbl_sel`=0 and the cosine table when `tbl_sel`=1. The write affects profiles whose correction pass begins afterwards. A write with `tbl_addr` ≥ M changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel present on `in_data` |
| in_data | input | SAMPLE_W | Unsigned pixel intensity |
| tbl_we | input | 1 | Weight-table write strobe |
| tbl_sel | input | 1 | 0 = sine table, 1 = cosine table |
| tbl_addr | input | IDX_W | Table entry index |
| tbl_data | input | COEF_W | Signed weight to store |
| done | output | 1 | One-cycle result strobe |
| sin_sum | output | SUM_W | Signed sine-weighted sum |
| cos_sum | output | SUM_W | Signed cosine-weighted sum |
| amp | output | SAMPLE_W+2 | Half the spread of corrected pixels |

## Verification
A constant profile and a pure ramp show whether the line is removed completely: their sums must collapse to the rounding residue, and a wrong slope or offset leaves a large index-weighted remainder. A ramp with a superimposed cosine and a single-pixel spike separate the quadrature sums from the max/min tracking. Full-scale and alternating extremes test the range of the corrected values. Random profiles, sent back to back and also with random gaps, check buffer alternation and the timing of the strobe. Table rewrites, including a write to an address beyond the profile length, confirm which entries the sums actually use.

// File: rtl/pdq_pkg.sv
package pdq_pkg;

   // table selector encoding on the write port
   typedef enum logic {
      TBL_SINE   = 1'b0,
      TBL_COSINE = 1'b1
   } tbl_sel_e;

   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic longint ceil_div(input longint a, input longint b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/pdq_line_fit.sv
// Collects pixel sums while a profile streams in, then derives slope and
// offset of the least-squares line in two registered stages.
module pdq_line_fit
   import pdq_pkg::*;
#(
   parameter int PIX_COUNT = 20,
   parameter int SAMPLE_W  = 12,
   parameter int FRAC_W    = 8,
   parameter int SHIFT_W   = 24,
   localparam int IDX_W    = idx_bits(PIX_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [SAMPLE_W-1:0]  in_data,
   output logic                 wr_en,
   output logic                 wr_bank,
   output logic [IDX_W-1:0]     wr_idx,
   output logic [SAMPLE_W-1:0]  wr_data,
   output logic                 fit_valid,
   output logic                 fit_bank,
   output logic signed [63:0]   slope_fx,
   output logic signed [63:0]   offset_fx
);
   localparam int     SY_W    = SAMPLE_W + idx_bits(PIX_COUNT + 1);
   localparam int     SXY_W   = SY_W + IDX_W;
   localparam longint N_L     = longint'(PIX_COUNT);
   localparam longint SX      = N_L * (N_L - 1) / 2;
   localparam longint DEN     = N_L * N_L * (N_L * N_L - 1) / 12;
   localparam longint SCALE   = longint'(1) <<< (SHIFT_W + FRAC_W);
   localparam longint RECIP_S = ceil_div(SCALE, DEN);
   localparam longint RECIP_M = ceil_div(SCALE, N_L);

   logic [IDX_W-1:0] fill_cnt;
   logic             wbank;
   logic [SY_W-1:0]  acc_y,  sy_n,  f0_sy;
   logic [SXY_W-1:0] acc_iy, sxy_n, f0_sxy;
   logic             f0_v, f0_bank;
   logic             f1_v, f1_bank;
   logic signed [63:0] f1_slope, f1_mean;
   logic signed [63:0] num_c, slope_c, mean_c, off_c;
   logic             last_in;

   assign last_in = (fill_cnt == IDX_W'(PIX_COUNT - 1));
   assign sy_n    = acc_y + SY_W'(in_data);
   assign sxy_n   = acc_iy + SXY_W'(in_data) * SXY_W'(fill_cnt);

   assign wr_en   = in_valid;
   assign wr_bank = wbank;
   assign wr_idx  = fill_cnt;
   assign wr_data = in_data;

   // R7: every PIX_COUNT accepted pixels close one profile
   always_ff @(posedge clk) begin
      if (rst) begin
         fill_cnt <= '0;
         wbank    <= 1'b0;
         acc_y    <= '0;
         acc_iy   <= '0;
         f0_v     <= 1'b0;
         f0_sy    <= '0;
         f0_sxy   <= '0;
         f0_bank  <= 1'b0;
      end else begin
         f0_v <= 1'b0;
         if (in_valid) begin
            if (last_in) begin
               f0_v     <= 1'b1;
               f0_sy    <= sy_n;
               f0_sxy   <= sxy_n;
               f0_bank  <= wbank;
               fill_cnt <= '0;
               wbank    <= ~wbank;
               acc_y    <= '0;
               acc_iy   <= '0;
            end else begin
               fill_cnt <= fill_cnt + 1'b1;
               acc_y    <= sy_n;
               acc_iy   <= sxy_n;
            end
         end
      end
   end

   // R2: covariance over variance through a reciprocal constant
   always_comb begin
      num_c   = N_L * $signed(64'(f0_sxy)) - SX * $signed(64'(f0_sy));
      slope_c = (num_c * RECIP_S) >>> SHIFT_W;
      mean_c  = ($signed(64'(f0_sy)) * RECIP_M) >>> SHIFT_W;
      off_c   = f1_mean - ((f1_slope * (N_L - 1)) >>> 1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         f1_v      <= 1'b0;
         f1_bank   <= 1'b0;
         f1_slope  <= '0;
         f1_mean   <= '0;
         fit_valid <= 1'b0;
         fit_bank  <= 1'b0;
         slope_fx  <= '0;
         offset_fx <= '0;
      end else begin
         f1_v      <= f0_v;
         fit_valid <= f1_v;
         if (f0_v) begin
            f1_slope <= slope_c;
            f1_mean  <= mean_c;
            f1_bank  <= f0_bank;
         end
         if (f1_v) begin
            slope_fx  <= f1_slope;
            offset_fx <= off_c;
            fit_bank  <= f1_bank;
         end
      end
   end

   assert_fit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      fit_valid |=> !fit_valid)
      else $error("fit result strobe longer than one cycle");

endmodule

// File: rtl/pdq_sample_bank.sv
// Two alternating profile buffers: one fills while the other is read.
module pdq_sample_bank
   import pdq_pkg::*;
#(
   parameter int PIX_COUNT = 20,
   parameter int SAMPLE_W  = 12,
   parameter int BANKS     = 2,
   localparam int IDX_W    = idx_bits(PIX_COUNT)
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic                wr_bank,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [SAMPLE_W-1:0] wr_data,
   input  logic                rd_bank,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [SAMPLE_W-1:0] rd_data
);
   logic [SAMPLE_W-1:0] bank_q [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [SAMPLE_W-1:0] mem [PIX_COUNT];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) mem[wr_idx] <= wr_data;
      end
      assign bank_q[b] = mem[rd_idx];
   end

   assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/pdq_coef_tables.sv
// Sine and cosine weight tables with one shared write port.
module pdq_coef_tables
   import pdq_pkg::*;
#(
   parameter int PIX_COUNT = 20,
   parameter int COEF_W    = 16,
   localparam int IDX_W    = idx_bits(PIX_COUNT)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic                     sel,
   input  logic [IDX_W-1:0]         addr,
   input  logic signed [COEF_W-1:0] wdata,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic signed [COEF_W-1:0] sin_coef,
   output logic signed [COEF_W-1:0] cos_coef
);
   logic signed [COEF_W-1:0] rd_q [2];
   logic                     addr_ok;

   // R10: addresses at or above the profile length are dropped
   assign addr_ok = (32'(addr) < PIX_COUNT);

   for (genvar t = 0; t < 2; t++) begin : g_tbl
      logic signed [COEF_W-1:0] mem [PIX_COUNT];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < PIX_COUNT; i++) mem[i] <= '0;
         end else if (we && addr_ok && (sel == 1'(t))) begin
            mem[addr] <= wdata;
         end
      end
      assign rd_q[t] = mem[rd_idx];
   end

   assign sin_coef = rd_q[TBL_SINE];
   assign cos_coef = rd_q[TBL_COSINE];

endmodule

// File: rtl/pdq_detrend_pass.sv
// Walks one buffered profile and emits the line-corrected pixels in order.
module pdq_detrend_pass
   import pdq_pkg::*;
#(
   parameter int PIX_COUNT = 20,
   parameter int SAMPLE_W  = 12,
   parameter int FRAC_W    = 8,
   parameter int C_W       = SAMPLE_W + 2,
   localparam int IDX_W    = idx_bits(PIX_COUNT)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic                  start_bank,
   input  logic signed [63:0]    slope_in,
   input  logic signed [63:0]    offset_in,
   input  logic [SAMPLE_W-1:0]   rd_data,
   output logic                  rd_active,
   output logic                  rd_bank,
   output logic [IDX_W-1:0]      rd_idx,
   output logic                  c_valid,
   output logic                  c_last,
   output logic [IDX_W-1:0]      c_idx,
   output logic signed [C_W-1:0] c_val
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_COUNT - 1);
   localparam longint           C_LIM    = longint'(1) <<< (C_W - 1);

   logic signed [63:0] slope_r, off_r;
   logic signed [63:0] y_q, line_q, full_c;

   // R3: corrected pixel in fixed point, floored back to an integer
   always_comb begin
      y_q    = $signed(64'(rd_data)) <<< FRAC_W;
      line_q = off_r + slope_r * $signed(64'(rd_idx));
      full_c = (y_q - line_q) >>> FRAC_W;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_active <= 1'b0;
         rd_bank   <= 1'b0;
         rd_idx    <= '0;
         slope_r   <= '0;
         off_r     <= '0;
         c_valid   <= 1'b0;
         c_last    <= 1'b0;
         c_idx     <= '0;
         c_val     <= '0;
      end else begin
         c_valid <= rd_active;
         c_last  <= rd_active && (rd_idx == LAST_IDX);
         if (rd_active) begin
            c_idx <= rd_idx;
            c_val <= C_W'(full_c);
         end
         if (start) begin
            rd_active <= 1'b1;
            rd_bank   <= start_bank;
            rd_idx    <= '0;
            slope_r   <= slope_in;
            off_r     <= offset_in;
         end else if (rd_active) begin
            rd_idx <= rd_idx + 1'b1;
            if (rd_idx == LAST_IDX) rd_active <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && rd_active) begin
         assert_corr_range_R3: assert (full_c >= -C_LIM && full_c < C_LIM)
            else $error("corrected pixel %0d outside %0d-bit range", full_c, C_W);
      end
   end

   assert_pass_overlap_R8: assert property (@(posedge clk) disable iff (rst)
      start |-> (!rd_active || rd_idx == LAST_IDX))
      else $error("new pass started while the previous one was mid-profile");

endmodule

// File: rtl/pdq_quad_accum.sv
// Sine/cosine weighted sums plus extreme tracking over one profile.
module pdq_quad_accum
   import pdq_pkg::*;
#(
   parameter int PIX_COUNT = 20,
   parameter int C_W       = 14,
   parameter int COEF_W    = 16,
   parameter int SUM_W     = C_W + COEF_W + idx_bits(PIX_COUNT),
   localparam int IDX_W    = idx_bits(PIX_COUNT),
   localparam int PROD_W   = C_W + COEF_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     c_valid,
   input  logic                     c_last,
   input  logic [IDX_W-1:0]         c_idx,
   input  logic signed [C_W-1:0]    c_val,
   input  logic signed [COEF_W-1:0] sin_coef,
   input  logic signed [COEF_W-1:0] cos_coef,
   output logic                     done,
   output logic signed [SUM_W-1:0]  sin_sum,
   output logic signed [SUM_W-1:0]  cos_sum,
   output logic [C_W-1:0]           amp
);
   logic signed [PROD_W-1:0] prod_s, prod_c;
   logic signed [SUM_W-1:0]  acc_s, acc_c, acc_s_n, acc_c_n;
   logic signed [C_W-1:0]    max_r, min_r, max_n, min_n;
   logic signed [C_W:0]      spread;
   logic                     first;

   assign first = (c_idx == '0);

   always_comb begin
      prod_s  = PROD_W'(c_val) * PROD_W'(sin_coef);
      prod_c  = PROD_W'(c_val) * PROD_W'(cos_coef);
      // R5 / R6: a new profile restarts the sums at its first pixel
      acc_s_n = (first ? '0 : acc_s) + SUM_W'(prod_s);
      acc_c_n = (first ? '0 : acc_c) + SUM_W'(prod_c);
      // R4: extremes over the whole corrected profile
      max_n   = (first || c_val > max_r) ? c_val : max_r;
      min_n   = (first || c_val < min_r) ? c_val : min_r;
      spread  = (C_W + 1)'(max_n) - (C_W + 1)'(min_n);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_s   <= '0;
         acc_c   <= '0;
         max_r   <= '0;
         min_r   <= '0;
         done    <= 1'b0;
         sin_sum <= '0;
         cos_sum <= '0;
         amp     <= '0;
      end else begin
         done <= 1'b0;
         if (c_valid) begin
            acc_s <= acc_s_n;
            acc_c <= acc_c_n;
            max_r <= max_n;
            min_r <= min_n;
            if (c_last) begin
               done    <= 1'b1;
               sin_sum <= acc_s_n;
               cos_sum <= acc_c_n;
               amp     <= C_W'(spread >>> 1);
            end
         end
      end
   end

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done)
      else $error("done held for more than one cycle");

   assert_index_order_R7: assert property (@(posedge clk) disable iff (rst)
      (c_valid && c_idx != '0) |-> ($past(c_valid) && ($past(c_idx) + 1'b1) == c_idx))
      else $error("corrected pixels arrived out of index order");

   assert_extreme_order_R4: assert property (@(posedge clk) disable iff (rst)
      (c_valid && c_idx != '0) |=> (max_r >= min_r))
      else $error("tracked maximum fell below tracked minimum");

endmodule

// File: rtl/pdq_detrend_quad.sv
module pdq_detrend_quad
   import pdq_pkg::*;
#(
   parameter int PIX_COUNT = 20,
   parameter int SAMPLE_W  = 12,
   parameter int COEF_W    = 16,
   parameter int FRAC_W    = 8,
   parameter int SHIFT_W   = 24,
   localparam int IDX_W    = idx_bits(PIX_COUNT),
   localparam int C_W      = SAMPLE_W + 2,
   localparam int SUM_W    = C_W + COEF_W + idx_bits(PIX_COUNT)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [SAMPLE_W-1:0]      in_data,
   input  logic                     tbl_we,
   input  logic                     tbl_sel,
   input  logic [IDX_W-1:0]         tbl_addr,
   input  logic signed [COEF_W-1:0] tbl_data,
   output logic                     done,
   output logic signed [SUM_W-1:0]  sin_sum,
   output logic signed [SUM_W-1:0]  cos_sum,
   output logic [C_W-1:0]           amp
);
   // elaboration-time parameter checks
   if (PIX_COUNT < 4) begin : g_bad_count
      $error("PIX_COUNT must be at least 4");
   end
   if (C_W > 18 || COEF_W > 18) begin : g_bad_mul
      $error("multiplier operands are limited to 18 bits");
   end
   if (SHIFT_W + FRAC_W > 40) begin : g_bad_shift
      $error("SHIFT_W + FRAC_W too large for 64-bit fit arithmetic");
   end

   logic                     wr_en, wr_bank;
   logic [IDX_W-1:0]         wr_idx;
   logic [SAMPLE_W-1:0]      wr_data, rd_data;
   logic                     fit_valid, fit_bank;
   logic signed [63:0]       slope_fx, offset_fx;
   logic                     rd_active, rd_bank;
   logic [IDX_W-1:0]         rd_idx;
   logic                     c_valid, c_last;
   logic [IDX_W-1:0]         c_idx;
   logic signed [C_W-1:0]    c_val;
   logic signed [COEF_W-1:0] sin_coef, cos_coef;

   pdq_line_fit #(
      .PIX_COUNT(PIX_COUNT), .SAMPLE_W(SAMPLE_W),
      .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)
   ) u_fit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
      .fit_valid(fit_valid), .fit_bank(fit_bank),
      .slope_fx(slope_fx), .offset_fx(offset_fx)
   );

   pdq_sample_bank #(
      .PIX_COUNT(PIX_COUNT), .SAMPLE_W(SAMPLE_W), .BANKS(2)
   ) u_bank (
      .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   pdq_detrend_pass #(
      .PIX_COUNT(PIX_COUNT), .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .C_W(C_W)
   ) u_pass (
      .clk(clk), .rst(rst), .start(fit_valid), .start_bank(fit_bank),
      .slope_in(slope_fx), .offset_in(offset_fx), .rd_data(rd_data),
      .rd_active(rd_active), .rd_bank(rd_bank), .rd_idx(rd_idx),
      .c_valid(c_valid), .c_last(c_last), .c_idx(c_idx), .c_val(c_val)
   );

   pdq_coef_tables #(
      .PIX_COUNT(PIX_COUNT), .COEF_W(COEF_W)
   ) u_tbl (
      .clk(clk), .rst(rst), .we(tbl_we), .sel(tbl_sel), .addr(tbl_addr),
      .wdata(tbl_data), .rd_idx(c_idx), .sin_coef(sin_coef), .cos_coef(cos_coef)
   );

   pdq_quad_accum #(
      .PIX_COUNT(PIX_COUNT), .C_W(C_W), .COEF_W(COEF_W), .SUM_W(SUM_W)
   ) u_acc (
      .clk(clk), .rst(rst), .c_valid(c_valid), .c_last(c_last), .c_idx(c_idx),
      .c_val(c_val), .sin_coef(sin_coef), .cos_coef(cos_coef),
      .done(done), .sin_sum(sin_sum), .cos_sum(cos_sum), .amp(amp)
   );

   // R8: a refill of the bank being read must stay behind the read pointer
   assert_bank_hazard_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_active && wr_bank == rd_bank) |-> (wr_idx < rd_idx))
      else $error("pixel overwritten before the correction pass read it");

endmodule

// File: tb/tb_pdq_detrend_quad.sv
module tb_pdq_detrend_quad;
   localparam int M     = 20;
   localparam int SW    = 12;
   localparam int KW    = 16;
   localparam int F     = 8;
   localparam int SH    = 24;
   localparam int IW    = 5;
   localparam int C_W   = SW + 2;
   localparam int SUM_W = C_W + KW + IW;
   localparam int LAT   = M + 4;
   localparam longint SXC = longint'(M) * (M - 1) / 2;
   localparam longint D   = longint'(M) * M * (longint'(M) * M - 1) / 12;
   localparam longint SC  = longint'(1) <<< (SH + F);
   localparam longint RS  = (SC + D - 1) / D;
   localparam longint RM  = (SC + M - 1) / M;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                    rst = 1'b1;
   logic                    in_valid = 1'b0;
   logic [SW-1:0]           in_data = '0;
   logic                    tbl_we = 1'b0;
   logic                    tbl_sel = 1'b0;
   logic [IW-1:0]           tbl_addr = '0;
   logic signed [KW-1:0]    tbl_data = '0;
   logic                    done;
   logic signed [SUM_W-1:0] sin_sum, cos_sum;
   logic [C_W-1:0]          amp;

   pdq_detrend_quad dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .done(done), .sin_sum(sin_sum), .cos_sum(cos_sum), .amp(amp)
   );

   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   longint sin_m [M];
   longint cos_m [M];
   int     prof [M];
   int     fill = 0;
   longint q_due[$], q_s[$], q_c[$], q_a[$];
   longint last_s = 0, last_c = 0, last_a = 0;
   string  tag = "R1";
   bit     finished = 1'b0;

   initial begin
      for (int i = 0; i < M; i++) begin
         sin_m[i] = 0;
         cos_m[i] = 0;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference: R2 fit, R3 correction, R4 amplitude, R5/R6 sums
   function automatic void model(output longint s, output longint c, output longint a);
      longint sy = 0, sxy = 0, num, slope, mean, off, e, mx = 0, mn = 0;
      for (int i = 0; i < M; i++) begin
         sy  += prof[i];
         sxy += longint'(i) * prof[i];
      end
      num   = M * sxy - SXC * sy;
      slope = (num * RS) >>> SH;
      mean  = (sy * RM) >>> SH;
      off   = mean - ((slope * (M - 1)) >>> 1);
      s = 0;
      c = 0;
      for (int i = 0; i < M; i++) begin
         e = ((longint'(prof[i]) <<< F) - off - slope * i) >>> F;
         s += e * sin_m[i];
         c += e * cos_m[i];
         if (i == 0 || e > mx) mx = e;
         if (i == 0 || e < mn) mn = e;
      end
      a = (mx - mn) >>> 1;
   endfunction

   // compared every cycle, away from the active edge
   always @(negedge clk) begin
      if (!rst && !finished) begin
         bit exp_done;
         longint s, c, a;
         exp_done = (q_due.size() != 0 && q_due[0] == cyc);
         chk({"R8 done timing ", tag}, longint'(done), longint'(exp_done));
         if (exp_done) begin
            void'(q_due.pop_front());
            last_s = q_s.pop_front();
            last_c = q_c.pop_front();
            last_a = q_a.pop_front();
            chk({"R5 sine sum ", tag},   longint'(sin_sum), last_s);
            chk({"R6 cosine sum ", tag}, longint'(cos_sum), last_c);
            chk({"R4 amplitude ", tag},  longint'(amp),     last_a);
         end else begin
            chk({"R9 hold sine ", tag},   longint'(sin_sum), last_s);
            chk({"R9 hold cosine ", tag}, longint'(cos_sum), last_c);
            chk({"R9 hold amp ", tag},    longint'(amp),     last_a);
         end
         // R10: model table update, out-of-range addresses dropped
         if (tbl_we && int'(tbl_addr) < M) begin
            if (tbl_sel) cos_m[tbl_addr] = longint'(tbl_data);
            else         sin_m[tbl_addr] = longint'(tbl_data);
         end
         // R7: pixel accepted at the next rising edge
         if (in_valid) begin
            prof[fill] = int'(in_data);
            fill++;
            if (fill == M) begin
               model(s, c, a);
               q_due.push_back(cyc + 1 + LAT);
               q_s.push_back(s);
               q_c.push_back(c);
               q_a.push_back(a);
               fill = 0;
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
         in_valid = 1'b0;
         tbl_we   = 1'b0;
      end
   endtask

   task automatic pix(input int v);
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      in_data  = SW'(v);
   endtask

   task automatic wtbl(input bit sel, input int addr, input int val);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      tbl_we   = 1'b1;
      tbl_sel  = sel;
      tbl_addr = IW'(addr);
      tbl_data = KW'(val);
   endtask

   task automatic drain();
      idle(1);
      while (q_due.size() != 0) idle(1);
      idle(2);
   endtask

   int wave [M];

   initial begin
      repeat (5) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk("R1 reset done", longint'(done), 0);
      chk("R1 reset sine", longint'(sin_sum), 0);
      chk("R1 reset amp",  longint'(amp), 0);

      // R1: tables still zero -> sums zero for a nonflat profile
      tag = "R1 empty tables";
      for (int i = 0; i < M; i++) pix((i * 613) % 4096);
      drain();

      // load weight tables
      tag = "R10 load";
      for (int i = 0; i < M; i++) begin
         wave[i] = int'($floor(1500.0 * $cos(6.2831853 * 0.22 * i) + 0.5));
         wtbl(1'b0, i, int'($floor(20000.0 * $sin(6.2831853 * 0.22 * i) + 0.5)));
         wtbl(1'b1, i, int'($floor(20000.0 * $cos(6.2831853 * 0.22 * i) + 0.5)));
      end
      idle(2);

      tag = "R2 constant";
      for (int i = 0; i < M; i++) pix(1000);
      drain();
      tag = "R2 ramp";
      for (int i = 0; i < M; i++) pix(100 + 37 * i);
      drain();
      tag = "R5 R6 ramp+cosine";
      for (int i = 0; i < M; i++) pix(2000 + 25 * i + wave[i]);
      drain();
      tag = "R4 spike";
      for (int i = 0; i < M; i++) pix(i == 7 ? 4095 : 0);
      drain();
      tag = "R3 full scale";
      for (int i = 0; i < M; i++) pix(4095);
      drain();
      tag = "R3 alternating";
      for (int i = 0; i < M; i++) pix((i % 2 == 0) ? 0 : 4095);
      drain();

      tag = "R8 back-to-back";
      for (int p = 0; p < 8; p++)
         for (int i = 0; i < M; i++) pix(int'($urandom_range(0, 4095)));
      drain();

      tag = "R7 gaps";
      for (int p = 0; p < 4; p++)
         for (int i = 0; i < M; i++) begin
            pix(int'($urandom_range(0, 4095)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
         end
      drain();

      tag = "R10 rewrite";
      wtbl(1'b1, 3, -17000);
      wtbl(1'b0, 0, 9000);
      idle(1);
      for (int i = 0; i < M; i++) pix(300 + ((i * 911) % 3000));
      drain();

      tag = "R10 ignored address";
      wtbl(1'b0, 25, 12345);
      wtbl(1'b1, 31, -12345);
      idle(1);
      for (int i = 0; i < M; i++) pix(300 + ((i * 911) % 3000));
      drain();

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule